// File: doc/BRIEF.md
# SHA-1 Single-Block Hash Accelerator with Bus Slave Port

This block hashes one 512-bit message block that software has already padded. It sits behind a 32-bit Wishbone slave port with zero wait states. Software pushes the sixteen message words into one write-only message register. The sixteenth push starts the compression on its own, and the block then runs one round per clock for 80 rounds. When it finishes, a status bit is set and an interrupt is raised. Software then pops the five digest words, H0 first, from one digest register.

Every block starts from the standard SHA-1 initial chaining values, so each block is hashed as a complete single-block message. A constant identity register and a constant register-count register let software check that the block is present. A write-only debug register holds the last value written to it on an output pin, where a harness can watch it.

Flow rules at the bus edge:
- A strobe is a request. The acknowledge is the grant, and it comes in the same cycle as the strobe whenever `active` is high, so the master never waits.
- While `active` is low, no request is acknowledged and no request has any effect.
- A message push made while a hash is running is acknowledged but dropped.

Top module: `sha1_wb_accel`

## Requirements
- R1: Byte offsets within the block are 0x00 register count, 0x04 identity, 0x08 control/status, 0x0C message push, 0x10 digest pop and 0x14 debug. A read of 0x00 returns 4 and a read of 0x04 returns 0x53484131. A read of 0x14 or of any unmapped offset returns 0.
- R2: After a synchronous active-high reset, the control/status register reads 0, `irq_o` is 0 and `dbg_word_o` is 0.
- R3: `wb_ack_o` is high in exactly the cycles in which `wb_cyc_i`, `wb_stb_i` and `active` are all high. With `active` low, a request is neither acknowledged nor acted on.
- R4: Each message push appends one word, with the first push becoming the most significant word of the block. After the sixteenth push, bit 0 (busy) of control/status reads 1 in the next cycle. Before the sixteenth push it reads 0.
- R5: Busy stays high for exactly 80 cycles after the cycle of the sixteenth push. It then clears, and bit 3 (done) of control/status reads 1.
- R6: After completion, consecutive digest pops return H0, H1, H2, H3 and H4. The sixth pop returns H0 again. The pop pointer returns to H0 when the first word of a new block is pushed.
- R7: The padded block for "abc" (0x61626380, fourteen zero words, 0x00000018) yields a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d. The padded empty message (0x80000000 followed by fifteen zero words), hashed next, yields da39a3ee 5e6b4b0d 3255bfef 95601890 afd80709.
- R8: `irq_o` rises when a hash completes. Writing 0 to control/status clears it. Writing a nonzero value to control/status leaves it set.
- R9: A message push while busy is dropped and does not alter the digest.
- R10: A write to the debug offset drives the written value onto `dbg_word_o`. It has no effect on busy or on the hash result.
- R11: Done clears when the first word of the next block is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active | input | 1 | Enables bus servicing |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe (request) |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Byte offset within the block |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid while acknowledged |
| wb_ack_o | output | 1 | Acknowledge, same cycle as the strobe |
| irq_o | output | 1 | Completion interrupt |
| dbg_word_o | output | 32 | Last value written to the debug offset |

## Verification
The assertions take for granted that `rst` is held through the first clock edge. They also assume a new block is never started while one is running. The port guarantees this by dropping pushes while busy, and the stimulus still pushes a word in the middle of a hash to confirm it. The stimulus changes bus signals one nanosecond after a rising edge and samples read data and acknowledge in the middle of the cycle. Each transfer is a single-cycle strobe, which is the only pattern a zero-wait-state slave needs to handle.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int DIG_WORDS = 5;
  localparam int ROUNDS    = 80;
  localparam int GRP_LEN   = 20;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t init_val(input int i);
    case (i)
      0:       return 32'h67452301;
      1:       return 32'hEFCDAB89;
      2:       return 32'h98BADCFE;
      3:       return 32'h10325476;
      default: return 32'hC3D2E1F0;
    endcase
  endfunction

  function automatic word_t round_k(input logic [1:0] grp);
    case (grp)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

  function automatic word_t round_f(input logic [1:0] grp, input word_t b,
                                    input word_t c, input word_t d);
    case (grp)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction
endpackage

// File: rtl/sha1_msg_buf.sv
module sha1_msg_buf
  import sha1_pkg::*;
#(
  parameter int N_WORDS = BLK_WORDS
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  word_t push_data,
  input  logic  roll,
  output word_t head
);
  localparam int TAP_3  = N_WORDS - 3;
  localparam int TAP_8  = N_WORDS - 8;
  localparam int TAP_14 = N_WORDS - 14;

  word_t slot_q [N_WORDS];
  word_t expand;
  logic  shift;

  assign shift  = push | roll;
  assign expand = rotl(slot_q[TAP_3] ^ slot_q[TAP_8] ^ slot_q[TAP_14] ^ slot_q[0], 1);
  assign head   = slot_q[0];

  for (genvar i = 0; i < N_WORDS - 1; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst)        slot_q[i] <= '0;
      else if (shift) slot_q[i] <= slot_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        slot_q[N_WORDS-1] <= '0;
    else if (push)  slot_q[N_WORDS-1] <= push_data;
    else if (roll)  slot_q[N_WORDS-1] <= expand;
  end
endmodule

// File: rtl/sha1_round_engine.sv
module sha1_round_engine
  import sha1_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  word_t                            w_head,
  output logic                             busy,
  output logic                             finish,
  output logic [DIG_WORDS-1:0][WORD_W-1:0] digest
);
  localparam int RND_W = $clog2(ROUNDS);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  word_t a_q, b_q, c_q, d_q, e_q;
  logic [RND_W-1:0] rnd_q;
  logic [1:0] grp;
  word_t t_sum;

  always_comb begin
    if (rnd_q < RND_W'(GRP_LEN))          grp = 2'd0;
    else if (rnd_q < RND_W'(2 * GRP_LEN)) grp = 2'd1;
    else if (rnd_q < RND_W'(3 * GRP_LEN)) grp = 2'd2;
    else                                  grp = 2'd3;
  end

  assign t_sum  = rotl(a_q, 5) + round_f(grp, b_q, c_q, d_q) + e_q + round_k(grp) + w_head;
  assign finish = busy && (rnd_q == LAST_RND);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      rnd_q <= '0;
      a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0; e_q <= '0;
      digest <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      rnd_q <= '0;
      a_q <= init_val(0); b_q <= init_val(1); c_q <= init_val(2);
      d_q <= init_val(3); e_q <= init_val(4);
    end else if (busy) begin
      a_q <= t_sum;
      b_q <= a_q;
      c_q <= rotl(b_q, 30);
      d_q <= c_q;
      e_q <= d_q;
      rnd_q <= rnd_q + 1'b1;
      if (finish) begin
        busy      <= 1'b0;
        digest[0] <= init_val(0) + t_sum;
        digest[1] <= init_val(1) + a_q;
        digest[2] <= init_val(2) + rotl(b_q, 30);
        digest[3] <= init_val(3) + c_q;
        digest[4] <= init_val(4) + d_q;
      end
    end
  end

  // R5
  rnd_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rnd_q <= LAST_RND));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/sha1_wb_regs.sv
module sha1_wb_regs
  import sha1_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             active,
  input  logic                             cyc,
  input  logic                             stb,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                adr,
  input  word_t                            wdata,
  output word_t                            rdata,
  output logic                             ack,
  input  logic                             busy,
  input  logic                             finish,
  input  logic [DIG_WORDS-1:0][WORD_W-1:0] digest,
  output logic                             push,
  output logic                             start,
  output logic                             irq,
  output word_t                            dbg_word
);
  localparam int CNT_W = $clog2(BLK_WORDS);
  localparam int PTR_W = $clog2(DIG_WORDS);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(BLK_WORDS - 1);
  localparam logic [PTR_W-1:0] LAST_DIG  = PTR_W'(DIG_WORDS - 1);
  localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_ID  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_OPS = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_MSG = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_DIG = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_DBG = ADDR_W'(8'h14);
  localparam word_t ID_CONST  = 32'h53484131;
  localparam word_t REG_COUNT = 32'd4;

  logic access, wr, rd, first;
  logic [CNT_W-1:0] wcnt_q;
  logic [PTR_W-1:0] rptr_q;
  logic done_q;

  assign access = cyc & stb & active;
  assign ack    = access;
  assign wr     = access & we;
  assign rd     = access & ~we;
  assign push   = wr && (adr == OFF_MSG) && !busy;
  assign start  = push && (wcnt_q == LAST_WORD);
  assign first  = push && (wcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q   <= '0;
      rptr_q   <= '0;
      done_q   <= 1'b0;
      irq      <= 1'b0;
      dbg_word <= '0;
    end else begin
      if (push) wcnt_q <= start ? '0 : wcnt_q + 1'b1;
      if (first)       done_q <= 1'b0;
      else if (finish) done_q <= 1'b1;
      if (finish) irq <= 1'b1;
      else if (wr && (adr == OFF_OPS) && (wdata == '0)) irq <= 1'b0;
      if (first) rptr_q <= '0;
      else if (rd && (adr == OFF_DIG))
        rptr_q <= (rptr_q == LAST_DIG) ? '0 : rptr_q + 1'b1;
      if (wr && (adr == OFF_DBG)) dbg_word <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (adr)
        OFF_CNT: rdata = REG_COUNT;
        OFF_ID:  rdata = ID_CONST;
        OFF_OPS: rdata = {28'd0, done_q, 2'b00, busy};
        OFF_DIG: rdata = digest[rptr_q];
        default: rdata = '0;
      endcase
    end
  end

  // R6
  rptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rptr_q <= LAST_DIG);
  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy));
  // R8
  irq_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> done_q);
  // R9
  idle_load_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (wcnt_q == '0));
  // R3
  inactive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(wcnt_q));
endmodule

// File: rtl/sha1_wb_accel.sv
module sha1_wb_accel
  import sha1_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic              irq_o,
  output logic [31:0]       dbg_word_o
);
  logic  push, start, busy, finish;
  word_t head;
  logic [DIG_WORDS-1:0][WORD_W-1:0] digest;

  sha1_wb_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .active(active),
    .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i), .adr(wb_adr_i),
    .wdata(wb_dat_i), .rdata(wb_dat_o), .ack(wb_ack_o),
    .busy(busy), .finish(finish), .digest(digest),
    .push(push), .start(start), .irq(irq_o), .dbg_word(dbg_word_o)
  );

  sha1_msg_buf #(.N_WORDS(BLK_WORDS)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_data(wb_dat_i),
    .roll(busy), .head(head)
  );

  sha1_round_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .w_head(head),
    .busy(busy), .finish(finish), .digest(digest)
  );
endmodule

// File: tb/sha1_wb_accel_tb_top.sv
module sha1_wb_accel_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic active = 1'b1;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0] adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat, dbg;
  logic ack, irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sha1_wb_accel dut_i (
    .clk(clk), .rst(rst), .active(active), .wb_cyc_i(cyc), .wb_stb_i(stb),
    .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .irq_o(irq), .dbg_word_o(dbg)
  );

  // register read vectors: {offset, expected}
  localparam logic [39:0] REG_VEC [7] = '{
    {8'h04, 32'h53484131},  // R1 identity
    {8'h00, 32'd4},         // R1 count
    {8'h08, 32'd0},         // R2 ops after reset
    {8'h14, 32'd0},         // R1 debug reads 0
    {8'h18, 32'd0},         // R1 unmapped
    {8'h1C, 32'd0},         // R1 unmapped
    {8'h10, 32'd0}          // digest before any hash
  };
  localparam logic [31:0] ABC_DIG [5] = '{32'ha9993e36, 32'h4706816a,
    32'hba3e2571, 32'h7850c26c, 32'h9cd0d89d};
  localparam logic [31:0] NUL_DIG [5] = '{32'hda39a3ee, 32'h5e6b4b0d,
    32'h3255bfef, 32'h95601890, 32'hafd80709};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wb_write(input logic [7:0] a, input logic [31:0] d, output bit acked);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    #4 acked = ack;
    @(posedge clk); #1;
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input logic [7:0] a, output logic [31:0] d, output bit acked);
    cyc = 1; stb = 1; we = 0; adr = a;
    #4 d = rdat; acked = ack;
    @(posedge clk); #1;
    cyc = 0; stb = 0;
  endtask

  function automatic logic [31:0] abc_word(input int i);
    return (i == 0) ? 32'h61626380 : (i == 15) ? 32'h18 : 32'h0;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    bit a;
    int busy_n;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check(irq == 0, "R2 irq", {31'd0, irq}, 0);
    check(dbg == 0, "R2 dbg", dbg, 0);

    for (int i = 0; i < 7; i++) begin
      wb_read(REG_VEC[i][39:32], d, a);
      check(d == REG_VEC[i][31:0], "R1/R2 register read", d, REG_VEC[i][31:0]);
      check(a, "R3 ack", {31'd0, a}, 1);
    end

    // R3: inactive requests ignored
    active = 0;
    wb_read(8'h04, d, a);
    check(!a, "R3 no ack inactive", {31'd0, a}, 0);
    wb_write(8'h0C, 32'hDEADBEEF, a);
    check(!a, "R3 no ack inactive write", {31'd0, a}, 0);
    active = 1;

    // R4: abc block
    for (int i = 0; i < 15; i++) wb_write(8'h0C, abc_word(i), a);
    wb_read(8'h08, d, a);
    check(d[0] == 0, "R4 not busy before 16th", d, 0);
    wb_write(8'h0C, abc_word(15), a);
    wb_write(8'h0C, 32'hFFFFFFFF, a);     // R9 dropped while busy
    check(a, "R9 busy push acked", {31'd0, a}, 1);
    wb_write(8'h14, 32'h0badf00d, a);     // R10
    check(dbg == 32'h0badf00d, "R10 dbg word", dbg, 32'h0badf00d);
    busy_n = 2;
    for (int j = 0; j < 200; j++) begin
      wb_read(8'h08, d, a);
      if (d[3]) break;
      if (d[0]) busy_n++;
    end
    check(busy_n == 80, "R5 busy cycles", busy_n, 80);
    check(d == 32'h8, "R5 done status", d, 32'h8);
    check(irq == 1, "R8 irq raised", {31'd0, irq}, 1);
    for (int k = 0; k < 5; k++) begin
      wb_read(8'h10, d, a);
      check(d == ABC_DIG[k], "R7/R9/R10 abc digest R6 order", d, ABC_DIG[k]);
    end
    wb_read(8'h10, d, a);
    check(d == ABC_DIG[0], "R6 wrap", d, ABC_DIG[0]);

    wb_write(8'h08, 32'h8, a);
    check(irq == 1, "R8 nonzero keeps irq", {31'd0, irq}, 1);
    wb_write(8'h08, 32'h0, a);
    check(irq == 0, "R8 ack clears irq", {31'd0, irq}, 0);

    // empty-message block; pointer currently at H1
    wb_write(8'h0C, 32'h80000000, a);
    wb_read(8'h08, d, a);
    check(d == 0, "R11 done cleared", d, 0);
    for (int i = 1; i < 16; i++) wb_write(8'h0C, 32'h0, a);
    for (int j = 0; j < 200; j++) begin
      wb_read(8'h08, d, a);
      if (d[3]) break;
    end
    for (int k = 0; k < 5; k++) begin
      wb_read(8'h10, d, a);
      check(d == NUL_DIG[k], "R7 empty digest R6 ptr reset", d, NUL_DIG[k]);
    end

    // R2: reset again
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    wb_read(8'h08, d, a);
    check(d == 0, "R2 ops after reset", d, 0);
    check(irq == 0 && dbg == 0, "R2 outputs after reset", dbg, 0);
    finish_run();
  end
endmodule